// File: doc/BRIEF.md
# Interrupt Mask and Status Controller with Fatal-Event Handling

This block gathers interrupt events from two groups of sources: a bus group of 16 event lines and a DMA group of 8 event lines. Every event is recorded in a sticky status register, whether or not it is enabled. A parameter sets whether each bit is fatal or nonfatal. From the status and enable registers the block produces four outputs: a summary flag for each group, which software can poll; an active-low interrupt request pin; and a single-cycle halt pulse for the instruction sequencer whenever a fatal event arrives.

The enable bits decide which events raise the pin. A fatal event still halts the sequencer and still shows in its group's summary flag when it is masked. A masked nonfatal event only records its status bit. The pin is sticky. Once asserted, it stays asserted through later masking and through the global interrupt-disable bit. It releases only when software has cleared, by writing ones, every status bit that caused it.

A simple register port gives access to the enables, the status registers, the global disable bit and the summary flags. Writes take effect at the clock edge. Reads are combinational.

Top module: `irq_mask_ctrl`

## Requirements
- R1: An event input bit that is high at a clock edge sets the matching status bit at that edge, whatever the state of its enable bit. Bus status reads at address 2. DMA status reads at address 3, in the low 8 bits.
- R2: Writing a one to a status bit clears that bit. Writing a zero leaves it unchanged. An event on the same bit in the same cycle as the clear wins, and the bit stays set.
- R3: A group summary flag is 1 while any status bit in that group is set and that bit is either enabled or fatal. The flags read at address 4: bit 1 is the bus group and bit 2 is the DMA group. They are also available as output ports.
- R4: A nonfatal event whose enable is clear sets neither the summary flag nor the pin, and it produces no halt pulse.
- R5: A fatal event whose enable is clear produces a halt pulse and sets its group summary flag. It leaves the pin deasserted. With the default parameters, the fatal bits are bus bits 15 to 8 and DMA bits 7 to 4.
- R6: An enabled event drives `irq_n` low one clock after its status bit is set. Bus enables are at address 0 and DMA enables at address 1, with 1 meaning enabled.
- R7: While the global disable bit (address 4, bit 0) is 1, the pin is never newly asserted. A pin that is already low stays low when the bit is set.
- R8: Clearing an enable bit while the pin is low does not release the pin.
- R9: `irq_n` returns high one clock after the last of the status bits that caused the assertion has been cleared.
- R10: `halt` is high for exactly one cycle for each clock edge at which at least one fatal event input is high.
- R11: After reset, `irq_n` is 1, `halt` and both summary flags are 0, and every register reads 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_evt | input | 16 | Bus-group event lines, high for one or more cycles |
| dma_evt | input | 8 | DMA-group event lines |
| wr_en | input | 1 | Register write strobe |
| addr | input | 3 | Register address |
| wdata | input | 16 | Write data |
| rdata | output | 16 | Read data for `addr`, combinational |
| bus_sum | output | 1 | Bus-group summary flag |
| dma_sum | output | 1 | DMA-group summary flag |
| irq_n | output | 1 | Active-low interrupt request |
| halt | output | 1 | One-cycle sequencer halt request |

## Verification
The assertions assume that the event lines and the register port are synchronous to `clk` and stable around the sampling edge. They also assume that status bits change only through events or write-one clears, so a rising `irq_n` can be traced back to a status write two samples earlier. The bench drives every input on the falling edge. It places each event and each status write in its own cycle, except in the one test that deliberately makes an event and a clear collide. Between vectors it clears the status and enables through the register port, so each vector starts from the reset-equivalent state.

// File: rtl/irq_mask_ctrl.sv
module irq_mask_ctrl #(
  parameter int BUS_W = 16,
  parameter int DMA_W = 8,
  parameter logic [BUS_W-1:0] BUS_FATAL = 16'hFF00,
  parameter logic [DMA_W-1:0] DMA_FATAL = 8'hF0,
  parameter int AW = 3
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [BUS_W-1:0] bus_evt,
  input  logic [DMA_W-1:0] dma_evt,
  input  logic             wr_en,
  input  logic [AW-1:0]    addr,
  input  logic [BUS_W-1:0] wdata,
  output logic [BUS_W-1:0] rdata,
  output logic             bus_sum,
  output logic             dma_sum,
  output logic             irq_n,
  output logic             halt
);
  localparam logic [AW-1:0] A_BEN = 0, A_DEN = 1, A_BST = 2, A_DST = 3, A_CTL = 4;
  localparam int PADW = BUS_W - DMA_W;

  logic [BUS_W-1:0] bus_en, bus_st, bus_cap;
  logic [DMA_W-1:0] dma_en, dma_st, dma_cap;
  logic             gdis, req;

  wire wr_bst = wr_en && addr == A_BST;
  wire wr_dst = wr_en && addr == A_DST;
  wire stwr   = wr_bst || wr_dst;

  wire [BUS_W-1:0] bus_clr = wr_bst ? wdata : '0;
  wire [DMA_W-1:0] dma_clr = wr_dst ? wdata[DMA_W-1:0] : '0;

  wire any_pend = |(bus_st & bus_en) || |(dma_st & dma_en);
  wire cap_live = |(bus_st & bus_cap) || |(dma_st & dma_cap);

  assign bus_sum = |(bus_st & (bus_en | BUS_FATAL));
  assign dma_sum = |(dma_st & (dma_en | DMA_FATAL));
  assign irq_n   = ~req;

  always_comb begin
    case (addr)
      A_BEN:   rdata = bus_en;
      A_DEN:   rdata = {{PADW{1'b0}}, dma_en};
      A_BST:   rdata = bus_st;
      A_DST:   rdata = {{PADW{1'b0}}, dma_st};
      A_CTL:   rdata = {{(BUS_W-3){1'b0}}, dma_sum, bus_sum, gdis};
      default: rdata = '0;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      bus_en <= '0; dma_en <= '0; gdis <= 1'b0;
      bus_st <= '0; dma_st <= '0;
      bus_cap <= '0; dma_cap <= '0;
      req <= 1'b0; halt <= 1'b0;
    end else begin
      if (wr_en && addr == A_BEN) bus_en <= wdata;
      if (wr_en && addr == A_DEN) dma_en <= wdata[DMA_W-1:0];
      if (wr_en && addr == A_CTL) gdis <= wdata[0];
      bus_st <= (bus_st & ~bus_clr) | bus_evt;
      dma_st <= (dma_st & ~dma_clr) | dma_evt;
      halt   <= |(bus_evt & BUS_FATAL) || |(dma_evt & DMA_FATAL);
      if (!req) begin
        if (!gdis && any_pend) begin
          req     <= 1'b1;
          bus_cap <= bus_st & bus_en;
          dma_cap <= dma_st & dma_en;
        end
      end else if (!cap_live) begin
        req <= 1'b0;
      end
    end
  end

  p_evt_sets_r1: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_evt != '0) |=> ((bus_st & $past(bus_evt)) == $past(bus_evt)));

  p_dma_evt_sets_r1: assert property (@(posedge clk) disable iff (!rst_n)
    (dma_evt != '0) |=> ((dma_st & $past(dma_evt)) == $past(dma_evt)));

  p_no_new_pin_r7: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(irq_n) |-> !$past(gdis));

  p_release_by_clear_r9: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(irq_n) |-> $past(stwr, 2));

  p_halt_fatal_r10: assert property (@(posedge clk) disable iff (!rst_n)
    halt |-> (|(bus_st & BUS_FATAL) || |(dma_st & DMA_FATAL)));
endmodule

// File: tb/irq_mask_ctrl_test.sv
module irq_mask_ctrl_test;
  logic        clk = 0, rst_n = 0;
  logic [15:0] bus_evt = '0, wdata = '0, rdata;
  logic [7:0]  dma_evt = '0;
  logic        wr_en = 0;
  logic [2:0]  addr = '0;
  logic        bus_sum, dma_sum, irq_n, halt;
  int          n_chk = 0, n_bad = 0;
  logic        done = 0;

  always #2.5 clk = ~clk;

  irq_mask_ctrl uut (.clk(clk), .rst_n(rst_n), .bus_evt(bus_evt), .dma_evt(dma_evt),
    .wr_en(wr_en), .addr(addr), .wdata(wdata), .rdata(rdata), .bus_sum(bus_sum),
    .dma_sum(dma_sum), .irq_n(irq_n), .halt(halt));

  // {bus_evt, dma_evt, bus_en, dma_en, exp bus_sum, dma_sum, pin_low, halt}
  localparam logic [51:0] VEC [8] = '{
    {16'h0001, 8'h00, 16'h0000, 8'h00, 4'b0000},
    {16'h0100, 8'h00, 16'h0000, 8'h00, 4'b1001},
    {16'h0001, 8'h00, 16'h0001, 8'h00, 4'b1010},
    {16'h0000, 8'h10, 16'h0000, 8'h00, 4'b0101},
    {16'h0000, 8'h01, 16'h0000, 8'h01, 4'b0110},
    {16'h0000, 8'h02, 16'h0000, 8'h01, 4'b0000},
    {16'h8000, 8'h00, 16'h8000, 8'h00, 4'b1011},
    {16'h0002, 8'h04, 16'h0002, 8'h00, 4'b1010}
  };

  task automatic chk(input string tag, input logic [15:0] act, input logic [15:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  task automatic wr(input logic [2:0] a, input logic [15:0] d);
    @(negedge clk); wr_en = 1; addr = a; wdata = d;
    @(negedge clk); wr_en = 0;
  endtask

  task automatic rd(input logic [2:0] a, output logic [15:0] d);
    addr = a; #0.5; d = rdata;
  endtask

  task automatic clean();
    wr(2, 16'hFFFF); wr(3, 16'hFFFF); wr(0, 0); wr(1, 0); wr(4, 0);
    @(negedge clk); @(negedge clk);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      n_bad++; n_chk++;
      $display("FAIL watchdog expired");
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  end

  initial begin
    logic [15:0] v;
    repeat (3) @(negedge clk);
    // R11 reset state
    chk("R11 irq_n", {15'd0, irq_n}, 16'd1);
    chk("R11 halt", {15'd0, halt}, 16'd0);
    for (int a = 0; a < 5; a++) begin rd(a[2:0], v); chk("R11 reg", v, 16'd0); end
    rst_n = 1;
    @(negedge clk);

    // vector table: R1 R3 R4 R5 R6 R10
    for (int i = 0; i < 8; i++) begin
      wr(0, VEC[i][27:12]); wr(1, {8'd0, VEC[i][11:4]});
      bus_evt = VEC[i][51:36]; dma_evt = VEC[i][35:28];
      @(negedge clk);
      bus_evt = '0; dma_evt = '0;
      chk("R5/R10 halt", {15'd0, halt}, {15'd0, VEC[i][0]});
      chk("R3 bus_sum", {15'd0, bus_sum}, {15'd0, VEC[i][3]});
      chk("R3 dma_sum", {15'd0, dma_sum}, {15'd0, VEC[i][2]});
      rd(4, v); chk("R3 flags reg", v, {13'd0, VEC[i][2], VEC[i][3], 1'b0});
      rd(2, v); chk("R1 bus status", v, VEC[i][51:36]);
      rd(3, v); chk("R1 dma status", v, {8'd0, VEC[i][35:28]});
      @(negedge clk);
      chk("R4/R6 pin", {15'd0, irq_n}, {15'd0, ~VEC[i][1]});
      chk("R10 halt one cycle", {15'd0, halt}, 16'd0);
      clean();
    end

    // R2 event wins over same-cycle clear
    bus_evt = 16'h0001; @(negedge clk); bus_evt = '0;
    @(negedge clk); wr_en = 1; addr = 2; wdata = 16'h0003; bus_evt = 16'h0001;
    @(negedge clk); wr_en = 0; bus_evt = '0;
    rd(2, v); chk("R2 event wins", v, 16'h0001);
    bus_evt = 16'h0002; @(negedge clk); bus_evt = '0;
    wr(2, 16'h0001);
    rd(2, v); chk("R2 w1c selective", v, 16'h0002);
    clean();

    // R7 disable blocks new assertion
    wr(4, 1); wr(0, 16'h0001);
    bus_evt = 16'h0001; @(negedge clk); bus_evt = '0;
    repeat (3) @(negedge clk);
    chk("R7 blocked", {15'd0, irq_n}, 16'd1);
    clean();

    // R7 existing stays, R8 mask does not release, R9 release timing
    wr(0, 16'h0003);
    bus_evt = 16'h0001; @(negedge clk); bus_evt = '0;
    @(negedge clk);
    chk("R6 pin low", {15'd0, irq_n}, 16'd0);
    wr(4, 1);
    @(negedge clk);
    chk("R7 stays low", {15'd0, irq_n}, 16'd0);
    wr(0, 0);
    @(negedge clk);
    chk("R8 stays low", {15'd0, irq_n}, 16'd0);
    chk("R8 summary drops", {15'd0, bus_sum}, 16'd0);
    wr(2, 16'h0001);
    chk("R9 not yet", {15'd0, irq_n}, 16'd0);
    @(negedge clk);
    chk("R9 released", {15'd0, irq_n}, 16'd1);
    clean();

    // R10 two-cycle fatal event gives two halt cycles then low
    dma_evt = 8'h80; @(negedge clk);
    chk("R10 halt c1", {15'd0, halt}, 16'd1);
    @(negedge clk); dma_evt = '0;
    chk("R10 halt c2", {15'd0, halt}, 16'd1);
    @(negedge clk);
    chk("R10 halt end", {15'd0, halt}, 16'd0);
    clean();

    done = 1;
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule